// File: doc/BRIEF.md
# I2C Dual Wiper Register Controller

This block is an I2C target that holds the settings of a pair of digitally controlled resistors. The two settings are 8-bit wiper codes, and each channel also has a shutdown flag. A bus master writes to the block in three bytes: an address byte, an instruction byte and a data byte. The instruction byte picks the channel and sets or clears its shutdown mode. A read is a single data byte that returns the code of the channel the last instruction picked. SCL and SDA are open-drain. The block only ever pulls SDA low, through `sda_oe`, and it never holds SCL.

Both bus lines pass through a synchronizer, and the transaction logic then runs in the system clock domain. Control sits in one state machine with these states:

- `ST_IDLE` waits for a START.
- `ST_ADDR`, `ST_CMD` and `ST_DATA` shift in a byte on each rising SCL.
- `ST_ADDR_ACK`, `ST_CMD_ACK` and `ST_DATA_ACK` hold SDA low for the ninth clock.
- `ST_RD_BYTE` drives the read byte.
- `ST_RD_ACK` leaves SDA free for the master's acknowledge.
- `ST_IGNORE` waits out the rest of the bus activity.

The transitions are as follows:

- START goes to `ST_ADDR` from any state, and STOP goes to `ST_IDLE` from any state.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` on a mismatch. This happens on the falling SCL after the eighth bit.
- `ST_ADDR_ACK` goes to `ST_CMD` for a write, or to `ST_RD_BYTE` for a read, on the falling SCL that ends the ninth clock.
- `ST_CMD` goes to `ST_CMD_ACK`, then to `ST_DATA`, then to `ST_DATA_ACK`, and finally to `ST_IGNORE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight falling edges, and then to `ST_IGNORE`.

Top module: `dpot_i2c_target`

## Requirements
- R1: After reset both wiper codes equal RESET_CODE (0x80 by default), both shutdown flags are 0 and channel 0 (`wiper_a`) is the read channel.
- R2: The 7-bit target address is 0b01011 followed by `addr_strap[1:0]` when PIN_STRAP=1, or by 0b11 when PIN_STRAP=0. Address bytes are sent MSB first, with bit 0 as R/W (0 = write). On a match the target pulls SDA low for the ninth SCL clock.
- R3: In a write, bit 7 of the instruction byte picks the channel (0 = `wiper_a`, 1 = `wiper_b`). Bits 5..0 are ignored. The data byte arrives MSB first. The instruction byte and the data byte are each acknowledged.
- R4: Instruction bit 6 is the shutdown bit. When it is 1, the write sets the chosen channel's shutdown flag and leaves its wiper code unchanged. When it is 0, the write clears the flag and stores the data byte as the code.
- R5: When the address does not match, the target leaves SDA released for the rest of the transaction, including all nine-clock acknowledge slots. It changes no output until the next START or STOP.
- R6: A read drives the code of the channel picked by the most recent acknowledged instruction byte. The byte is sent MSB first, with each bit changed only while SCL is low. SDA is then released for the master's acknowledge.
- R7: A START or STOP that arrives before the data byte's acknowledge clock completes leaves both wiper codes and both shutdown flags unchanged. The codes and flags change only when that acknowledge clock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_strap | input | 2 | Low address bits from pin straps (used when PIN_STRAP=1) |
| wiper_a | output | 8 | Stored code of channel 0 |
| wiper_b | output | 8 | Stored code of channel 1 |
| shdn_a | output | 1 | Shutdown flag of channel 0 |
| shdn_b | output | 1 | Shutdown flag of channel 1 |

## Verification
The bench places two instances on one shared open-drain bus. The first is built with PIN_STRAP=1, with its straps tied to 0b01, so it answers at 0x2D. The second is built with PIN_STRAP=0 and answers at 0x2F. Both use the default RESET_CODE and SYNC_STAGES=2. This pairing exercises the following:

- Address discrimination between the two instances.
- Rejection of a neighbouring address.
- A fixed-address target seeing the other target's traffic.

The known three-clock synchronizer latency lets the reference model be compared against both instances on every clock.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int          DPOT_BYTE_W  = 8;
    localparam logic [4:0]  DPOT_ADDR_HI = 5'b01011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } dpot_state_e;
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;

    // Bus idles high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
    parameter int                 N_CH       = 2,
    parameter int                 CODE_W     = 8,
    parameter logic [CODE_W-1:0]  RESET_CODE = 8'h80,
    localparam int                CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic                          wr_sd,
    input  logic [CODE_W-1:0]             wr_data,
    output logic [N_CH-1:0][CODE_W-1:0]   code_o,
    output logic [N_CH-1:0]               shdn_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) begin
                code_o[i] <= RESET_CODE;
                shdn_o[i] <= 1'b0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_CH; i++) begin
                if (wr_ch == CH_W'(i)) begin
                    shdn_o[i] <= wr_sd;
                    if (!wr_sd) code_o[i] <= wr_data;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_chk
            AST_SHDN_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_ch == CH_W'(g) && wr_sd) |=> ($stable(code_o[g]) && shdn_o[g])) // R4
                else $error("shutdown write altered stored code");
        end
    endgenerate
endmodule

// File: rtl/dpot_i2c_target.sv
module dpot_i2c_target
    import dpot_pkg::*;
#(
    parameter bit          PIN_STRAP   = 1'b1,
    parameter logic [7:0]  RESET_CODE  = 8'h80,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_strap,
    output logic [7:0] wiper_a,
    output logic [7:0] wiper_b,
    output logic       shdn_a,
    output logic       shdn_b
);
    localparam int N_CH  = 2;
    localparam int CNT_W = $clog2(DPOT_BYTE_W) + 1;

    dpot_state_e state, nxt;
    logic [CNT_W-1:0]        bit_cnt;
    logic [DPOT_BYTE_W-1:0]  shreg;
    logic                    sel_q, sd_q;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]              my_addr;
    logic                    addr_hit, byte_full, wr_en;
    logic [N_CH-1:0][DPOT_BYTE_W-1:0] codes;
    logic [N_CH-1:0]         shdns;

    dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign my_addr   = {DPOT_ADDR_HI, (PIN_STRAP ? addr_strap : 2'b11)};
    assign byte_full = (bit_cnt == CNT_W'(DPOT_BYTE_W));
    assign addr_hit  = (shreg[7:1] == my_addr);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = shreg[0] ? ST_RD_BYTE : ST_CMD;
                ST_CMD:      if (scl_fall && byte_full) nxt = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (scl_fall && byte_full) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_IGNORE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == CNT_W'(DPOT_BYTE_W - 1)) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            sel_q   <= 1'b0;
            sd_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det || stop_det || nxt != state) begin
                bit_cnt <= '0;
            end else if (scl_rise && (state == ST_ADDR || state == ST_CMD || state == ST_DATA)) begin
                shreg   <= {shreg[DPOT_BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (scl_fall && state == ST_RD_BYTE) begin
                shreg   <= {shreg[DPOT_BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (state == ST_ADDR_ACK && nxt == ST_RD_BYTE) shreg <= codes[sel_q];
            if (state == ST_CMD_ACK && nxt == ST_DATA) begin
                sel_q <= shreg[7];
                sd_q  <= shreg[6];
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK: sda_oe = 1'b1;
            ST_DATA_ACK: begin
                sda_oe = 1'b1;
                wr_en  = scl_fall && !start_det && !stop_det;
            end
            ST_RD_BYTE: sda_oe = ~shreg[DPOT_BYTE_W-1];
            default: ;
        endcase
    end

    dpot_wiper_bank #(.N_CH(N_CH), .CODE_W(DPOT_BYTE_W), .RESET_CODE(RESET_CODE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(sel_q), .wr_sd(sd_q),
        .wr_data(shreg), .code_o(codes), .shdn_o(shdns)
    );

    assign wiper_a = codes[0];
    assign wiper_b = codes[1];
    assign shdn_a  = shdns[0];
    assign shdn_b  = shdns[1];

    AST_SDA_FREE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe) // R5
        else $error("SDA held while not addressed");
    AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s) // R2
        else $error("SDA pulled while SCL high");
    AST_SDA_FREE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s) // R6
        else $error("SDA released while SCL high");
    AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_BYTE) |-> (bit_cnt < CNT_W'(DPOT_BYTE_W))) // R6
        else $error("read byte overran");
    AST_WIPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({wiper_a, wiper_b, shdn_a, shdn_b})) // R7
        else $error("outputs changed without commit");
endmodule

// File: tb/tb_dpot_i2c_target.sv
module tb_dpot_i2c_target;
    localparam int          Q       = 8;
    localparam int          LAT     = 3;
    localparam logic [6:0]  ADDR_S  = 7'h2D;
    localparam logic [6:0]  ADDR_F  = 7'h2F;
    localparam logic [17:0] RST_VEC = {2'b00, 8'h80, 8'h80};
    localparam int          WD_LIM  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe_s, oe_f, sda_line;
    logic [7:0] wa_s, wb_s, wa_f, wb_f;
    logic sa_s, sb_s, sa_f, sb_f;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [17:0] mdl_s = RST_VEC;
    logic [17:0] mdl_f = RST_VEC;
    logic [17:0] pend_s = RST_VEC;
    logic [17:0] pend_f = RST_VEC;
    bit          pend_en = 1'b0;
    bit          sel_s = 1'b0;
    bit          sel_f = 1'b0;
    bit          run_cmp = 1'b0;
    logic [17:0] ps [LAT];
    logic [17:0] pf [LAT];

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~oe_s & ~oe_f;

    dpot_i2c_target #(.PIN_STRAP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(oe_s),
        .addr_strap(2'b01), .wiper_a(wa_s), .wiper_b(wb_s), .shdn_a(sa_s), .shdn_b(sb_s)
    );
    dpot_i2c_target #(.PIN_STRAP(1'b0)) dut_fix (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(oe_f),
        .addr_strap(2'b00), .wiper_a(wa_f), .wiper_b(wb_f), .shdn_a(sa_f), .shdn_b(sb_f)
    );

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected outputs follow the model by the synchronizer plus commit latency.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                ps[i] <= RST_VEC;
                pf[i] <= RST_VEC;
            end
        end else begin
            ps[0] <= mdl_s;
            pf[0] <= mdl_f;
            for (int i = 1; i < LAT; i++) begin
                ps[i] <= ps[i-1];
                pf[i] <= pf[i-1];
            end
        end
        if (cyc > WD_LIM) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, WD_LIM);
            finish_run();
        end
    end

    // Per-clock comparison for R3 R4 R7
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk({sb_s, sa_s, wb_s, wa_s} == ps[LAT-1], "R3 R4 R7", "outputs of strapped target",
                int'({sb_s, sa_s, wb_s, wa_s}), int'(ps[LAT-1]));
            chk({sb_f, sa_f, wb_f, wa_f} == pf[LAT-1], "R2 R4 R7", "outputs of fixed target",
                int'({sb_f, sa_f, wb_f, wa_f}), int'(pf[LAT-1]));
        end
    end

    function automatic logic [17:0] apply(input logic [17:0] m, input logic [7:0] c, input logic [7:0] d);
        logic [17:0] r;
        r = m;
        if (c[7]) begin
            r[17] = c[6];
            if (!c[6]) r[15:8] = d;
        end else begin
            r[16] = c[6];
            if (!c[6]) r[7:0] = d;
        end
        return r;
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        chk(sda_line == !exp_ack, tag, "acknowledge level", int'(sda_line), int'(!exp_ack));
        scl_m = 1'b0;
        if (pend_en) begin
            mdl_s = pend_s;
            mdl_f = pend_f;
            pend_en = 1'b0;
        end
        hold(Q);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d, input string tag);
        bit hs, hf, hit;
        hs = (a == ADDR_S);
        hf = (a == ADDR_F);
        hit = hs | hf;
        start_c();
        send_byte({a, 1'b0}, hit, hit ? "R2" : "R5");
        send_byte(c, hit, hit ? tag : "R5");
        if (hs) sel_s = c[7];
        if (hf) sel_f = c[7];
        pend_s  = hs ? apply(mdl_s, c, d) : mdl_s;
        pend_f  = hf ? apply(mdl_f, c, d) : mdl_f;
        pend_en = 1'b1;
        send_byte(d, hit, hit ? tag : "R5");
        stop_c();
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        v = '0;
        start_c();
        send_byte({a, 1'b1}, 1'b1, "R2");
        for (int i = 0; i < 8; i++) begin
            scl_m = 1'b1; hold(Q);
            v = {v[6:0], sda_line};
            scl_m = 1'b0; hold(Q);
        end
        chk(sda_line == 1'b1, tag, "SDA free for master acknowledge", int'(sda_line), 1);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        scl_m = 1'b0; hold(Q);
        stop_c();
        chk(v == exp, tag, "read byte", int'(v), int'(exp));
    endtask

    task automatic abort_wr(input logic [7:0] c, input bit use_stop);
        start_c();
        send_byte({ADDR_S, 1'b0}, 1'b1, "R7");
        send_byte(c, 1'b1, "R7");
        sel_s = c[7];
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        if (use_stop) begin
            stop_c();
        end else begin
            start_c();
            stop_c();
        end
        hold(Q);
        chk({sb_s, sa_s, wb_s, wa_s} == mdl_s, "R7", "state after aborted write",
            int'({sb_s, sa_s, wb_s, wa_s}), int'(mdl_s));
    endtask

    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(2);
        // R1 reset state
        chk(wa_s == 8'h80 && wb_s == 8'h80, "R1", "reset codes", int'({wb_s, wa_s}), 16'h8080);
        chk(!sa_s && !sb_s && !sa_f && !sb_f, "R1", "reset shutdown flags",
            int'({sa_s, sb_s, sa_f, sb_f}), 0);
        chk(!oe_s && !oe_f, "R1", "SDA released after reset", int'({oe_s, oe_f}), 0);
        run_cmp = 1'b1;

        rd(ADDR_F, 8'h80, "R1 R6");                      // R1 read channel 0 after reset
        wr(ADDR_S, 8'h00, 8'h3C, "R3");                  // R3 channel 0
        wr(ADDR_S, 8'h95, 8'hA5, "R3");                  // R3 channel 1, ignored low bits set
        chk(wb_s == 8'hA5 && wa_s == 8'h3C, "R3", "codes after two writes", int'({wb_s, wa_s}), 16'hA53C);
        rd(ADDR_S, 8'hA5, "R6");                         // R6 follows last instruction
        wr(ADDR_S, 8'h40, 8'h11, "R4");                  // R4 shutdown keeps code
        chk(sa_s && wa_s == 8'h3C, "R4", "shutdown with code kept", int'({sa_s, wa_s}), 9'h13C);
        rd(ADDR_S, 8'h3C, "R4 R6");
        wr(ADDR_S, 8'h00, 8'h55, "R4");                  // R4 clears shutdown
        chk(!sa_s && wa_s == 8'h55, "R4", "shutdown cleared by write", int'({sa_s, wa_s}), 9'h055);
        wr(ADDR_F, 8'hC0, 8'h99, "R2 R4");               // R2 fixed variant
        chk(sb_f && wb_f == 8'h80 && wb_s == 8'hA5, "R2", "fixed address only",
            int'({sb_f, wb_f}), 9'h180);
        wr(7'h2C, 8'h00, 8'h01, "R5");                   // R5 neighbour address
        wr(7'h6D, 8'h80, 8'h02, "R5");                   // R5 wrong fixed bits
        chk(wa_s == 8'h55 && wb_s == 8'hA5, "R5", "codes after mismatch", int'({wb_s, wa_s}), 16'hA555);
        abort_wr(8'h80, 1'b0);                           // R7 repeated start
        abort_wr(8'h00, 1'b1);                           // R7 stop
        rd(ADDR_S, sel_s ? mdl_s[15:8] : mdl_s[7:0], "R6");
        wr(ADDR_F, 8'h80, 8'h7E, "R3");
        rd(ADDR_F, 8'h7E, "R6");
        wr(ADDR_S, 8'hBF, 8'hFF, "R3 R4");
        wr(ADDR_S, 8'h80, 8'h00, "R3 R4");
        rd(ADDR_S, 8'h00, "R6");
        hold(20);
        finish_run();
    end
endmodule